// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a byte-addressed serial EEPROM that sits behind a four-wire SPI port. It samples the SPI pins, the hold input and the write-protect input in a fast system clock domain. It decodes the command byte, then either streams array bytes or a status byte out on the serial output, or gathers write data into a page buffer. The array is a behavioural register store inside the block.

A write is committed only when chip select rises cleanly on a byte boundary. The commit then runs a self-timed busy cycle, and the array changes when that cycle ends. Block protection can lock the upper quarter, the upper half or the whole array. A hardware write-protect pin can freeze the protection settings. A hold input pauses a transfer mid-byte without losing its place. With `ADDR_W` = 15 and `PAGE_W` = 6 the block is a 32 KiB part with 64-byte pages. The defaults keep the behavioural store small.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the serial output is disabled, the status byte reads 0x00, and every array byte reads 0xFF.
- R2: Serial input is sampled on rising SCK and serial output changes after falling SCK, most significant bit first. This holds whether SCK idles low or high. The output enable is high only while chip select is low and the transfer is not on hold.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect when its command byte completes.
- R4: Opcode 0x05 returns the status byte on every following byte while chip select stays low. The layout is bit 7 write-protect-enable, bits 6:4 zero, bits 3:2 block-protect level, bit 1 write-enable latch, bit 0 busy.
- R5: Opcode 0x03 followed by a 16-bit address streams bytes from consecutive addresses. Only the low `ADDR_W` address bits are used, and the address wraps from the last byte to 0.
- R6: Opcode 0x02 followed by a 16-bit address loads data bytes into the page buffer, starting at the address's offset within its page. The offset wraps inside the page and a later byte replaces an earlier one at the same offset. Bytes of the page that were not loaded keep their old contents.
- R7: A page write or status write is committed only if chip select rises after a whole number of bytes and at least one data byte was received. Otherwise nothing changes and no busy cycle starts.
- R8: A commit holds busy high for exactly `WR_CYCLES` clocks. The array bytes change at the end of that window, and the write-enable latch is clear once busy drops.
- R9: While busy, every command other than 0x05 is ignored.
- R10: Opcode 0x02 or 0x01 issued while the write-enable latch is clear is ignored.
- R11: The block-protect level selects the locked region: 1 locks the upper quarter of the array, 2 the upper half, 3 all of it, and 0 locks nothing. A page write that targets a locked page changes nothing and starts no busy cycle.
- R12: Opcode 0x01 with one data byte copies data bit 7 into write-protect-enable and data bits 3:2 into the block-protect level, then runs a busy cycle. It is refused, leaving the status unchanged and starting no busy cycle, when write-protect-enable is set and the write-protect pin is low.
- R13: Taking the hold input low while SCK is low pauses the transfer. SCK edges are then ignored and the output is disabled. Releasing hold while SCK is low resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_en | output | 1 | Output enable for the serial output pad |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low hardware write protect for the status settings |

## Verification
The bench fills a small 256-byte array one page at a time, using both clock polarities, and reads it back through a wrapping sequential read. A read pointer that failed to wrap, or a byte landing on the wrong edge, would corrupt that comparison. It aims writes at offsets near the page end, overfills a page and cuts a transfer off mid-byte. An offset that carried into the next page, or an aborted write that still committed, would show up as changed bytes next door or as a busy flag that should not be there. It also tries every protection level against pages just inside and just outside the locked region, issues commands during the busy window, and toggles the write-protect pin against a status write. A hold in the middle of a byte must leave the read data intact; a design that counted the edges seen during hold would shift the rest of the stream.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR_HI, PH_ADDR_LO, PH_READ, PH_LOAD, PH_SRDATA, PH_STAT, PH_SKIP
  } phase_t;

  // top2 holds the two most significant address bits of the target page
  function automatic logic blk_locked(input logic [1:0] level, input logic [1:0] top2);
    case (level)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic wpen, input logic [1:0] level,
                                             input logic wel, input logic busy);
    return {wpen, 3'b000, level, wel, busy};
  endfunction
endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_s
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= pins;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign pins_s = stg[STAGES-1];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
  parameter int unsigned CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (start && cnt == '0)   cnt <= CW'(CYCLES);
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
  parameter int PAGE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          load,
  input  logic [PAGE_W-1:0]             off,
  input  logic [7:0]                    din,
  output logic [(1<<PAGE_W)-1:0][7:0]   data,
  output logic [(1<<PAGE_W)-1:0]        valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= '0;
    end else if (clr) begin
      valid <= '0;
    end else if (load) begin
      data[off]  <= din;
      valid[off] <= 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-PAGE_W-1:0]      page,
  input  logic [(1<<PAGE_W)-1:0][7:0]   pdata,
  input  logic [(1<<PAGE_W)-1:0]        pvalid,
  input  logic [ADDR_W-1:0]             raddr,
  output logic [7:0]                    rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i]) cells[{page, PAGE_W'(i)}] <= pdata[i];
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6,
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_en,
  input  logic hold_n,
  input  logic wp_n
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  logic sck_s, cs_n_s, mosi_s, hold_n_s, wp_n_s;
  eeprom_pin_sync #(.WIDTH(5), .STAGES(2), .RST_VAL(5'b01011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins({spi_sck, spi_cs_n, spi_mosi, hold_n, wp_n}),
    .pins_s({sck_s, cs_n_s, mosi_s, hold_n_s, wp_n_s})
  );

  // edge detection and hold state
  logic sck_q, cs_q, hold_act;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; hold_act <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (!sck_s) hold_act <= ~hold_n_s;
    end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = ~cs_n_s & ~hold_act &  sck_s & ~sck_q;
  assign sck_fall = ~cs_n_s & ~hold_act & ~sck_s &  sck_q;
  assign cs_fall  = ~cs_n_s &  cs_q;
  assign cs_rise  =  cs_n_s & ~cs_q;

  // serial engine state
  phase_t            phase;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic              miso_q;
  logic              wel, wpen, is_write, sr_got, sr_wpen_new, pend_page;
  logic [1:0]        bp, sr_bp_new;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] rd_ptr;
  logic [PG_W-1:0]   pg_sel;
  logic [PAGE_W-1:0] pg_off;

  logic busy, done;
  logic [PAGE-1:0][7:0] pbuf_data;
  logic [PAGE-1:0]      pbuf_valid;
  logic [7:0]           rdata;

  logic              byte_done;
  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] addr_cur;
  logic [7:0]        status;
  logic              page_locked, wr_whole, page_go, sr_go, wr_start, commit_go;

  assign byte_done   = sck_rise & (bit_cnt == 3'd7);
  assign rx_byte     = {rx_sh, mosi_s};
  assign addr_cur    = ADDR_W'({addr_hi, rx_byte});
  assign status      = status_byte(wpen, bp, wel, busy);
  assign page_locked = blk_locked(bp, pg_sel[PG_W-1 -: 2]);
  assign wr_whole    = cs_rise & (bit_cnt == 3'd0);
  assign page_go     = wr_whole & (phase == PH_LOAD) & (|pbuf_valid) & ~page_locked;
  assign sr_go       = wr_whole & (phase == PH_SRDATA) & sr_got & ~(wpen & ~wp_n_s);
  assign wr_start    = page_go | sr_go;
  assign commit_go   = done & pend_page;

  eeprom_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(done)
  );

  eeprom_page_buffer #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n),
    .clr(cs_fall & ~busy),
    .load(byte_done & (phase == PH_LOAD)),
    .off(pg_off), .din(rx_byte),
    .data(pbuf_data), .valid(pbuf_valid)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_go), .page(pg_sel),
    .pdata(pbuf_data), .pvalid(pbuf_valid),
    .raddr((phase == PH_ADDR_LO) ? addr_cur : rd_ptr),
    .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0; miso_q <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; is_write <= 1'b0; sr_got <= 1'b0;
      sr_wpen_new <= 1'b0; sr_bp_new <= '0; pend_page <= 1'b0;
      addr_hi <= '0; rd_ptr <= '0; pg_sel <= '0; pg_off <= '0;
    end else begin
      if (cs_fall) begin
        phase <= PH_CMD; bit_cnt <= '0; sr_got <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= {rx_sh[5:0], mosi_s};
      end
      if (sck_fall) begin
        miso_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            if (busy && rx_byte != OP_RDSR) phase <= PH_SKIP;
            else begin
              case (rx_byte)
                OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                OP_RDSR:  begin tx_sh <= status; phase <= PH_STAT; end
                OP_READ:  begin is_write <= 1'b0; phase <= PH_ADDR_HI; end
                OP_WRITE: begin is_write <= 1'b1; phase <= wel ? PH_ADDR_HI : PH_SKIP; end
                OP_WRSR:  phase <= wel ? PH_SRDATA : PH_SKIP;
                default:  phase <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR_HI: begin addr_hi <= rx_byte[HI_W-1:0]; phase <= PH_ADDR_LO; end
          PH_ADDR_LO: begin
            if (is_write) begin
              pg_sel <= addr_cur[ADDR_W-1:PAGE_W];
              pg_off <= addr_cur[PAGE_W-1:0];
              phase  <= PH_LOAD;
            end else begin
              tx_sh  <= rdata;
              rd_ptr <= addr_cur + 1'b1;
              phase  <= PH_READ;
            end
          end
          PH_READ:   begin tx_sh <= rdata; rd_ptr <= rd_ptr + 1'b1; end
          PH_STAT:   tx_sh <= status;
          PH_LOAD:   pg_off <= pg_off + 1'b1;
          PH_SRDATA: if (!sr_got) begin
                       sr_got <= 1'b1; sr_wpen_new <= rx_byte[7]; sr_bp_new <= rx_byte[3:2];
                     end
          default: ;
        endcase
      end
      if (wr_start) begin
        pend_page <= page_go;
        if (sr_go) begin wpen <= sr_wpen_new; bp <= sr_bp_new; end
      end
      if (done) wel <= 1'b0;
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_en = ~cs_n_s & ~hold_act;
endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_s,
  input logic       cs_fall,
  input logic       cs_rise,
  input logic       hold_act,
  input logic       spi_miso_en,
  input logic [2:0] bit_cnt,
  input logic       busy,
  input logic       wr_start,
  input logic       wel,
  input logic       wpen,
  input logic [1:0] bp,
  input logic       wp_n_s
);
  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  p_so_off_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !spi_miso_en);

  p_so_off_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !spi_miso_en);

  p_hold_freezes_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_n_s && !cs_fall) |=> $stable(bit_cnt));

  p_start_raises_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> busy);

  p_busy_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == WR_CYCLES);

  p_wel_clear_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_no_start_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_start);

  p_partial_byte_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != 3'd0) |-> !wr_start);

  p_wp_pin_freezes_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_n_s) |=> ($stable(bp) && wpen));
endmodule

bind spi_eeprom_slave eeprom_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (.*);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int AW = 8;
  localparam int PW = 4;
  localparam int WC = 300;
  localparam int H  = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PG = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_en;
  always #4 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .hold_n(hold_n), .wp_n(wp_n)
  );

  logic [7:0] exp_mem [DEPTH];
  int  n_run = 0, n_bad = 0;
  bit  mode3 = 1'b0;
  bit  finished = 1'b0;

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 13 + 7) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = mode3;
    tick(H);
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic desel();
    if (!mode3) begin sck = 1'b0; tick(H); end
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic xfer(input logic [7:0] dout, input int nbits, input int hold_bit,
                      output logic [7:0] din);
    din = '0;
    for (int k = 0; k < nbits; k++) begin
      sck = 1'b0; mosi = dout[7-k]; tick(H);
      if (k == hold_bit) begin
        hold_n = 1'b0; tick(H);
        check("R13 output off in hold", 32'(miso_en), 32'd0);
        sck = 1'b1; tick(H); sck = 1'b0; tick(H);
        hold_n = 1'b1; tick(H);
      end
      din[7-k] = miso;
      sck = 1'b1; tick(H);
    end
  endtask

  task automatic put(input logic [7:0] d);
    logic [7:0] junk;
    xfer(d, 8, -1, junk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); put(op); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); put(8'h05); xfer(8'h00, 8, -1, s); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int t = 0; t < 40; t++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    check("R8 busy ends", 32'd1, 32'd0);
  endtask

  // commit says whether the requirements predict the array to change
  task automatic do_write(input logic [15:0] a, input int n, input int seed, input bit commit);
    int base, off;
    sel(); put(8'h02); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < n; i++) put(pat(i, seed));
    desel();
    if (commit) begin
      base = int'(a[AW-1:0]) & ~(PG - 1);
      for (int i = 0; i < n; i++) begin
        off = (int'(a[PW-1:0]) + i) % PG;
        exp_mem[base + off] = pat(i, seed);
      end
    end
  endtask

  task automatic read_chk(input logic [15:0] a, input int n, input int hold_byte, input string req);
    logic [7:0] d;
    int idx;
    sel(); put(8'h03); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, (i == hold_byte) ? 3 : -1, d);
      idx = (int'(a[AW-1:0]) + i) % DEPTH;
      check(req, 32'(d), 32'(exp_mem[idx]));
    end
    desel();
  endtask

  task automatic expect_status(input logic [7:0] e, input string req);
    logic [7:0] s;
    rdsr(s);
    check(req, 32'(s), 32'(e));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, junk;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    tick(10);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 output enable after reset", 32'(miso_en), 32'd0);
    expect_status(8'h00, "R1 status after reset");
    read_chk(16'h0000, 2, -1, "R1 erased array");

    // R2 output enable follows select
    sel();
    check("R2 output enabled when selected", 32'(miso_en), 32'd1);
    put(8'h00);
    desel();
    check("R2 output disabled when deselected", 32'(miso_en), 32'd0);

    // R3 latch set and clear
    cmd1(8'h06); expect_status(8'h02, "R3 latch set");
    cmd1(8'h04); expect_status(8'h00, "R3 latch cleared");

    // R10 write without latch
    do_write(16'h0010, 4, 1, 1'b0);
    expect_status(8'h00, "R10 no busy without latch");
    read_chk(16'h0010, 4, -1, "R10 array untouched");

    // R6 R8 fill every page, alternating clock polarity
    for (int p = 0; p < DEPTH / PG; p++) begin
      mode3 = p[0];
      cmd1(8'h06);
      do_write(16'((p * PG) | 16'h4000), PG, p + 2, 1'b1);
      expect_status(8'h03, "R8 busy and latch during commit");
      wait_idle();
      expect_status(8'h00, "R8 latch cleared after commit");
    end

    // R5 R2 full wrapping read, clock idle high
    mode3 = 1'b1;
    read_chk(16'h0000, DEPTH + 4, -1, "R5 R2 sequential read with wrap");
    mode3 = 1'b0;
    read_chk(16'hFFF0, 20, -1, "R5 upper address bits ignored");

    // R6 offset wrap inside page, partial page
    cmd1(8'h06); do_write(16'h003E, 4, 40, 1'b1); wait_idle();
    read_chk(16'h0020, 3 * PG, -1, "R6 wrap inside page");
    // R6 overfilled page, later bytes win
    cmd1(8'h06); do_write(16'h0070, PG + 2, 41, 1'b1); wait_idle();
    read_chk(16'h0070, PG, -1, "R6 overfill");

    // R7 partial byte abort
    cmd1(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h50); put(8'hAA); put(8'h55);
    xfer(8'h0F, 3, -1, junk);
    desel();
    expect_status(8'h02, "R7 no busy after partial byte");
    read_chk(16'h0050, 2, -1, "R7 array untouched after abort");
    sel(); put(8'h02); put(8'h00); put(8'h50); desel();
    expect_status(8'h02, "R7 no busy without data");

    // R9 commands ignored while busy; R4 repeated status
    do_write(16'h0050, 3, 42, 1'b1);
    cmd1(8'h04);
    sel(); put(8'h05);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, 8, -1, s);
      check("R4 R9 repeated status during busy", 32'(s), 32'h03);
    end
    desel();
    do_write(16'h0060, 4, 43, 1'b0);
    wait_idle();
    read_chk(16'h0050, 2 * PG, -1, "R9 second write ignored");

    // R12 R11 protection levels
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h04); desel();
    wait_idle();
    expect_status(8'h04, "R12 level one written");
    cmd1(8'h06);
    do_write(16'h00C0, 2, 44, 1'b0);
    expect_status(8'h06, "R11 upper quarter locked");
    do_write(16'h00B0, 2, 45, 1'b1);
    expect_status(8'h07, "R11 below quarter writable");
    wait_idle();
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h08); desel();
    wait_idle();
    cmd1(8'h06);
    do_write(16'h0080, 2, 46, 1'b0);
    expect_status(8'h0A, "R11 upper half locked");
    do_write(16'h0070, 2, 47, 1'b1);
    wait_idle();
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h0C); desel();
    wait_idle();
    cmd1(8'h06);
    do_write(16'h0000, 2, 48, 1'b0);
    expect_status(8'h0E, "R11 whole array locked");
    cmd1(8'h04);
    read_chk(16'h0000, DEPTH, -1, "R11 array after protection tests");

    // R10 status write without latch
    sel(); put(8'h01); put(8'h00); desel();
    expect_status(8'h0C, "R10 status write ignored without latch");

    // R12 write-protect pin
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h8C); desel();
    wait_idle();
    expect_status(8'h8C, "R12 enable flag written");
    wp_n = 1'b0;
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h00); desel();
    expect_status(8'h8E, "R12 refused with pin low");
    wp_n = 1'b1;
    sel(); put(8'h01); put(8'h00); desel();
    wait_idle();
    expect_status(8'h00, "R12 accepted with pin high");

    // R13 hold mid-byte, both clock polarities
    mode3 = 1'b0;
    read_chk(16'h0020, 4, 1, "R13 read across hold");
    mode3 = 1'b1;
    read_chk(16'h0090, 4, 2, "R13 read across hold idle high");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule